// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Line Controller

This block turns up to sixteen external pins into interrupt requests. Each of its sixteen lines takes its input from one pin chosen among seven input ports. Every port offers a pin with the same index as the line. The chosen pin is synchronised and watched for a rising edge, a falling edge or either one. A qualifying edge latches a sticky pending flag, and that flag stays set until software clears it. Software can also set a pending flag directly, with no edge on the pin.

Lines 0 to 4 each drive a dedicated request wire. Lines 5 to 9 combine into one shared request, and lines 10 to 15 combine into another. A separate event mask turns any trigger into a single-cycle event pulse for that line, whatever the interrupt mask holds. A plain synchronous register bus configures the block and reads it back. Reads are combinational and a write takes effect on the clock edge where it is sampled.

Top module: `ext_irq_ctrl`

## Requirements
- R1: Each selected pin passes through a two-flop synchroniser and is compared against its prior synchronised sample. For a pin change placed just after clock edge E0, the pending flag is still clear after edge E2 and is set after edge E3.
- R2: The rise-select register (address 2) and the fall-select register (address 3) hold one bit per line. A line whose rise bit is set reacts to a 0-to-1 change, and a line whose fall bit is set reacts to a 1-to-0 change. With both bits set, the line reacts to either change. With neither set, the line never reacts.
- R3: A trigger sets pending bit n only while bit n of the interrupt mask (address 0) is 1. A request output is driven only by lines whose pending bit and mask bit are both 1.
- R4: When bit n of the event mask (address 1) is 1, each trigger on line n gives a one-cycle pulse on evt_o[n] one clock later. This happens whatever the interrupt mask holds.
- R5: Writing the pending register (address 5) clears every bit written as 1. Bits written as 0 keep their value.
- R6: The source of line n is a 4-bit code held in port-select word n/4 (addresses 8 to 11), at bit offset (n mod 4)*4. Codes 0 to 6 pick port 0 to 6, and that port's pin n is at pins_i[port*16+n]. Codes 7 to 15 pick no pin. A pin on any port other than the chosen one never affects the line.
- R7: Writing 1 to bit n of the software-trigger register (address 4) acts as a trigger on line n. It sets the pending flag if the mask allows it, and gives an event pulse if the event mask allows it. This register always reads as zero.
- R8: irq_line_o[k] equals the request of line k for k = 0 to 4. irq_mid_o is the OR of the requests of lines 5 to 9, and irq_hi_o is the OR of the requests of lines 10 to 15.
- R9: A pending flag stays set until it is cleared. Edges that arrive while it is set are absorbed, so a single clear leaves it at 0.
- R10: If a trigger and a write-1 clear of the same line land on the same clock edge, the pending flag ends up set.
- R11: After a synchronous reset, all registers read 0, all request outputs are 0 and no event pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_i | input | NUM_PORTS*16 | Asynchronous pins, port p pin n at bit p*16+n |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 4 | Register address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Combinational read data |
| evt_o | output | 16 | One-cycle event pulses, one per line |
| irq_line_o | output | 5 | Dedicated requests of lines 0 to 4 |
| irq_mid_o | output | 1 | Shared request of lines 5 to 9 |
| irq_hi_o | output | 1 | Shared request of lines 10 to 15 |

## Verification
The bench drives an edge on the same clock edge as a clear of that line. A design where the clear wins would lose that interrupt. It also counts clocks from a pin change to the pending flag, which exposes a missing or extra synchroniser stage. It toggles pins on ports that are not selected and uses select codes that pick no pin. A field decoded at the wrong offset or word would then trigger the wrong line. It also checks that the upper lines reach only their shared outputs, that a zero write leaves pending bits alone, and that edges repeated while a flag is set are absorbed.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
    localparam int EIRQ_LINES   = 16;
    localparam int EIRQ_PORTS   = 7;
    localparam int SEL_W        = 4;
    localparam int DATA_W       = EIRQ_LINES;
    localparam int ADDR_W       = 4;
    localparam int SEL_PER_WORD = DATA_W / SEL_W;
    localparam int SEL_WORDS    = EIRQ_LINES / SEL_PER_WORD;
    localparam int DIRECT_N     = 5;
    localparam int MID_LO       = 5;
    localparam int MID_HI       = 9;
    localparam int HI_LO        = 10;
    localparam int HI_HI        = EIRQ_LINES - 1;

    typedef enum logic [ADDR_W-1:0] {
        RA_IMASK = 4'd0,
        RA_EMASK = 4'd1,
        RA_RISE  = 4'd2,
        RA_FALL  = 4'd3,
        RA_SWTRG = 4'd4,
        RA_PEND  = 4'd5,
        RA_SEL0  = 4'd8,
        RA_SEL1  = 4'd9,
        RA_SEL2  = 4'd10,
        RA_SEL3  = 4'd11
    } reg_addr_e;

    typedef struct packed {
        logic [EIRQ_LINES-1:0] imask;
        logic [EIRQ_LINES-1:0] emask;
        logic [EIRQ_LINES-1:0] rise;
        logic [EIRQ_LINES-1:0] fall;
    } line_cfg_t;

    function automatic logic is_sel_addr(input logic [ADDR_W-1:0] a);
        return (a >= RA_SEL0) && (a <= RA_SEL3);
    endfunction

    function automatic logic [EIRQ_LINES-1:0] or_range(input logic [EIRQ_LINES-1:0] v,
                                                        input int lo, input int hi);
        logic r;
        r = 1'b0;
        for (int i = lo; i <= hi; i++) r |= v[i];
        return {{(EIRQ_LINES-1){1'b0}}, r};
    endfunction
endpackage

// File: rtl/eirq_src_select.sv
module eirq_src_select
    import eirq_pkg::*;
#(
    parameter int NUM_PORTS = EIRQ_PORTS,
    parameter int LINES     = EIRQ_LINES
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_PORTS*LINES-1:0] pins_i,
    input  logic [LINES*SEL_W-1:0] sel_i,
    input  logic [LINES-1:0]       rise_en_i,
    input  logic [LINES-1:0]       fall_en_i,
    output logic [LINES-1:0]       hit_o
);
    logic [LINES-1:0] raw;
    logic [LINES-1:0] meta_q, sync_q, prev_q;

    for (genvar n = 0; n < LINES; n++) begin : g_mux
        logic [SEL_W-1:0] code;
        assign code = sel_i[n*SEL_W +: SEL_W];
        always_comb begin
            raw[n] = 1'b0;
            for (int p = 0; p < NUM_PORTS; p++)
                if (code == SEL_W'(p)) raw[n] = pins_i[p*LINES + n];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= raw;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign hit_o = (rise_en_i & sync_q & ~prev_q) | (fall_en_i & ~sync_q & prev_q);
endmodule

// File: rtl/eirq_pending.sv
module eirq_pending
    import eirq_pkg::*;
#(
    parameter int LINES = EIRQ_LINES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] hw_hit_i,
    input  logic [LINES-1:0] sw_hit_i,
    input  logic [LINES-1:0] clr_i,
    input  logic [LINES-1:0] imask_i,
    input  logic [LINES-1:0] emask_i,
    output logic [LINES-1:0] pend_o,
    output logic [LINES-1:0] evt_o
);
    logic [LINES-1:0] trig, set_v, pend_q, evt_q;

    assign trig  = hw_hit_i | sw_hit_i;
    assign set_v = trig & imask_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            evt_q  <= '0;
        end else begin
            pend_q <= set_v | (pend_q & ~clr_i);
            evt_q  <= trig & emask_i;
        end
    end

    assign pend_o = pend_q;
    assign evt_o  = evt_q;

    AST_PEND_NEEDS_MASK: assert property (@(posedge clk) disable iff (rst)
        ((pend_q & ~$past(pend_q) & ~$past(imask_i)) == '0)); // R3
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
        (($past(clr_i) & ~$past(set_v) & pend_q) == '0)); // R5
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (($past(set_v) & ~pend_q) == '0)); // R10
    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
        (($past(pend_q) & ~$past(clr_i) & ~pend_q) == '0)); // R9
    AST_EVT_NEEDS_MASK: assert property (@(posedge clk) disable iff (rst)
        ((evt_q & ~$past(emask_i)) == '0)); // R4
endmodule

// File: rtl/eirq_req_group.sv
module eirq_req_group
    import eirq_pkg::*;
(
    input  logic [EIRQ_LINES-1:0] pend_i,
    input  logic [EIRQ_LINES-1:0] imask_i,
    output logic [DIRECT_N-1:0]   irq_line_o,
    output logic                  irq_mid_o,
    output logic                  irq_hi_o
);
    logic [EIRQ_LINES-1:0] req;
    logic [EIRQ_LINES-1:0] mid_v, hi_v;

    assign req = pend_i & imask_i;

    for (genvar k = 0; k < DIRECT_N; k++) begin : g_direct
        assign irq_line_o[k] = req[k];
    end

    assign mid_v     = or_range(req, MID_LO, MID_HI);
    assign hi_v      = or_range(req, HI_LO, HI_HI);
    assign irq_mid_o = mid_v[0];
    assign irq_hi_o  = hi_v[0];

    AST_REQ_NEEDS_PEND: assert final ((irq_line_o & ~pend_i[DIRECT_N-1:0]) == '0); // R8
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
    import eirq_pkg::*;
#(
    parameter int NUM_PORTS = EIRQ_PORTS
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_PORTS*EIRQ_LINES-1:0] pins_i,
    input  logic                          bus_wr_i,
    input  logic [ADDR_W-1:0]             bus_addr_i,
    input  logic [DATA_W-1:0]             bus_wdata_i,
    output logic [DATA_W-1:0]             bus_rdata_o,
    output logic [EIRQ_LINES-1:0]         evt_o,
    output logic [DIRECT_N-1:0]           irq_line_o,
    output logic                          irq_mid_o,
    output logic                          irq_hi_o
);
    line_cfg_t                   cfg_q;
    logic [DATA_W-1:0]           sel_q [SEL_WORDS];
    logic [EIRQ_LINES*SEL_W-1:0] sel_flat;
    logic [EIRQ_LINES-1:0]       hw_hit, sw_hit, clr_v, pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            for (int w = 0; w < SEL_WORDS; w++) sel_q[w] <= '0;
        end else if (bus_wr_i) begin
            case (bus_addr_i)
                RA_IMASK: cfg_q.imask <= bus_wdata_i;
                RA_EMASK: cfg_q.emask <= bus_wdata_i;
                RA_RISE:  cfg_q.rise  <= bus_wdata_i;
                RA_FALL:  cfg_q.fall  <= bus_wdata_i;
                default: begin
                    if (is_sel_addr(bus_addr_i))
                        sel_q[bus_addr_i - RA_SEL0] <= bus_wdata_i;
                end
            endcase
        end
    end

    for (genvar w = 0; w < SEL_WORDS; w++) begin : g_flat
        assign sel_flat[w*DATA_W +: DATA_W] = sel_q[w];
    end

    assign sw_hit = (bus_wr_i && bus_addr_i == RA_SWTRG) ? bus_wdata_i : '0;
    assign clr_v  = (bus_wr_i && bus_addr_i == RA_PEND)  ? bus_wdata_i : '0;

    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            RA_IMASK: bus_rdata_o = cfg_q.imask;
            RA_EMASK: bus_rdata_o = cfg_q.emask;
            RA_RISE:  bus_rdata_o = cfg_q.rise;
            RA_FALL:  bus_rdata_o = cfg_q.fall;
            RA_PEND:  bus_rdata_o = pend;
            default: begin
                if (is_sel_addr(bus_addr_i))
                    bus_rdata_o = sel_q[bus_addr_i - RA_SEL0];
            end
        endcase
    end

    eirq_src_select #(.NUM_PORTS(NUM_PORTS), .LINES(EIRQ_LINES)) u_src (
        .clk(clk), .rst(rst), .pins_i(pins_i), .sel_i(sel_flat),
        .rise_en_i(cfg_q.rise), .fall_en_i(cfg_q.fall), .hit_o(hw_hit)
    );

    eirq_pending #(.LINES(EIRQ_LINES)) u_pend (
        .clk(clk), .rst(rst), .hw_hit_i(hw_hit), .sw_hit_i(sw_hit), .clr_i(clr_v),
        .imask_i(cfg_q.imask), .emask_i(cfg_q.emask), .pend_o(pend), .evt_o(evt_o)
    );

    eirq_req_group u_grp (
        .pend_i(pend), .imask_i(cfg_q.imask),
        .irq_line_o(irq_line_o), .irq_mid_o(irq_mid_o), .irq_hi_o(irq_hi_o)
    );

    AST_SWTRG_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_addr_i == RA_SWTRG) |-> (bus_rdata_o == '0)); // R7
    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (pend == '0 && evt_o == '0)); // R11
endmodule

// File: tb/tb_ext_irq_ctrl.sv
module tb_ext_irq_ctrl;
    import eirq_pkg::*;
    localparam int NP = EIRQ_PORTS;
    localparam int NL = EIRQ_LINES;

    logic clk = 1'b0, rst = 1'b1;
    logic [NP*NL-1:0] pins = '0;
    logic bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic [NL-1:0] evt;
    logic [DIRECT_N-1:0] irq_line;
    logic irq_mid, irq_hi;

    int n_run = 0, n_fail = 0, evt_cnt = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    ext_irq_ctrl dut (
        .clk(clk), .rst(rst), .pins_i(pins), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .evt_o(evt),
        .irq_line_o(irq_line), .irq_mid_o(irq_mid), .irq_hi_o(irq_hi)
    );

    always @(negedge clk) if (!rst) evt_cnt += $countones(evt);

    // fields: line[12:9] port[8:6] rise[5] fall[4] start[3] end[2] expect[1] spare[0]
    localparam logic [12:0] VEC [8] = '{
        {4'd0,  3'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
        {4'd1,  3'd2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        {4'd2,  3'd6, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
        {4'd3,  3'd1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
        {4'd6,  3'd3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
        {4'd11, 3'd4, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
        {4'd15, 3'd5, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
        {4'd9,  3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [6:0] irq_exp(input int line);
        logic [6:0] r;
        r = '0;
        if (line < DIRECT_N) r[line] = 1'b1;
        else if (line <= MID_HI) r[5] = 1'b1;
        else r[6] = 1'b1;
        return r;
    endfunction

    initial begin
        #1_000_000;
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: got hang expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [DATA_W-1:0] d;
        idle(3);
        @(negedge clk) rst = 1'b0;
        idle(2);

        // R11 reset state
        for (int a = 0; a < 12; a++) begin
            rd(a[ADDR_W-1:0], d);
            check("R11 reset reg", d, 0);
        end
        check("R11 reset irq", {irq_hi, irq_mid, irq_line}, 0);
        check("R11 reset evt", evt_cnt, 0);

        // table walk: R2 edge selection, R6 port decode, R8 grouping
        for (int i = 0; i < 8; i++) begin
            int ln, pt;
            logic [12:0] v;
            v  = VEC[i];
            ln = int'(v[12:9]);
            pt = int'(v[8:6]);
            pins = '0;
            for (int w = 0; w < SEL_WORDS; w++)
                wr(RA_SEL0 + ADDR_W'(w), (w == ln / 4) ? DATA_W'(pt << ((ln % 4) * 4)) : '0);
            wr(RA_RISE,  v[5] ? DATA_W'(1 << ln) : '0);
            wr(RA_FALL,  v[4] ? DATA_W'(1 << ln) : '0);
            wr(RA_IMASK, DATA_W'(1 << ln));
            pins[pt*NL + ln] = v[3];
            idle(6);
            wr(RA_PEND, '1);
            pins[pt*NL + ln] = v[2];
            idle(6);
            rd(RA_PEND, d);
            check("R2 table pending", d, v[1] ? (1 << ln) : 0);
            check("R8 table request", {irq_hi, irq_mid, irq_line}, v[1] ? irq_exp(ln) : 0);
            wr(RA_PEND, '1);
        end

        // R6: line 4 on port 3; toggling port 2 pin 4 does nothing
        pins = '0;
        for (int w = 0; w < SEL_WORDS; w++) wr(RA_SEL0 + ADDR_W'(w), '0);
        wr(RA_SEL1, 16'h0003);
        wr(RA_RISE, 16'h0010); wr(RA_FALL, 16'h0010); wr(RA_IMASK, 16'h0010);
        pins[2*NL + 4] = 1'b1; idle(6);
        rd(RA_PEND, d);
        check("R6 unselected port ignored", d, 0);
        pins[3*NL + 4] = 1'b1; idle(6);
        rd(RA_PEND, d);
        check("R6 selected port", d, 16'h0010);
        wr(RA_PEND, '1);
        // R6: code 7 selects nothing
        wr(RA_SEL1, 16'h0007);
        idle(4); wr(RA_PEND, '1);
        pins = '1; idle(6); pins = '0; idle(6);
        rd(RA_PEND, d);
        check("R6 code 7 no source", d, 0);
        wr(RA_SEL1, 16'h0000);

        // R3: mask off blocks pending and request
        pins = '0;
        wr(RA_RISE, 16'h0001); wr(RA_FALL, 16'h0000); wr(RA_IMASK, 16'h0000);
        idle(4);
        pins[0] = 1'b1; idle(6);
        rd(RA_PEND, d);
        check("R3 masked edge", d, 0);
        check("R3 masked request", irq_line, 0);

        // R1 timing and R10 collision: line 0 rise, port 0
        wr(RA_IMASK, 16'h0001);
        pins[0] = 1'b0; idle(6); wr(RA_PEND, '1);
        @(negedge clk) pins[0] = 1'b1;   // after E0
        @(negedge clk);                   // after E1
        @(negedge clk);                   // after E2
        rd(RA_PEND, d);
        check("R1 not yet pending", d, 0);
        bus_wr = 1'b1; bus_wdata = 16'h0001; bus_addr = RA_PEND;
        @(negedge clk);                   // after E3
        bus_wr = 1'b0;
        rd(RA_PEND, d);
        check("R10 set beats clear", d, 16'h0001);
        check("R1 request on line 0", irq_line, 5'b00001);

        // R5: write 0 keeps, write 1 clears
        wr(RA_PEND, 16'hFFFE);
        rd(RA_PEND, d);
        check("R5 zero write keeps", d, 16'h0001);

        // R9: extra edges absorbed
        pins[0] = 1'b0; idle(5); pins[0] = 1'b1; idle(6);
        wr(RA_PEND, 16'h0001);
        rd(RA_PEND, d);
        check("R9 single clear", d, 0);
        check("R5 request dropped", irq_line, 0);

        // R7 software trigger
        wr(RA_IMASK, 16'h2000);
        wr(RA_SWTRG, 16'h2004);
        rd(RA_PEND, d);
        check("R7 sw trigger respects mask", d, 16'h2000);
        check("R8 line 13 on shared high", {irq_hi, irq_mid, irq_line}, 7'b1000000);
        rd(RA_SWTRG, d);
        check("R7 sw reg reads zero", d, 0);
        wr(RA_PEND, '1);

        // R4 events independent of interrupt mask
        wr(RA_IMASK, 16'h0000);
        wr(RA_EMASK, 16'h0100);
        wr(RA_RISE, 16'h0100);
        idle(4);
        evt_cnt = 0;
        wr(RA_SWTRG, 16'h0100); idle(3);
        check("R4 sw event pulse", evt_cnt, 1);
        pins[8] = 1'b1; idle(6);
        check("R4 hw event pulse", evt_cnt, 2);
        rd(RA_PEND, d);
        check("R4 event leaves pending", d, 0);
        wr(RA_EMASK, 16'h0000);
        wr(RA_SWTRG, 16'h0100); idle(3);
        check("R4 event masked", evt_cnt, 2);

        // R11 reset clears live state
        wr(RA_IMASK, 16'hFFFF); wr(RA_SWTRG, 16'hFFFF);
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        rd(RA_PEND, d);
        check("R11 pending after reset", d, 0);
        rd(RA_IMASK, d);
        check("R11 mask after reset", d, 0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule